// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block presents interrupts to one processor. It keeps a single pending slot and drives one interrupt line. The slot is a 32-bit word: the processor's current priority sits in the top byte and the pending source number fills the low 24 bits. A source number of zero means the slot is empty. Beside the word it holds the priority of the pending interrupt and a separate inter-processor-interrupt (IPI) request priority. Priorities compare numerically, and a lower value is more favoured. 0xFF is the least favoured value.

A source controller offers interrupts as (source number, priority) pairs. A more favoured offer displaces the one already waiting. The displaced source is reported on a reject pulse so that it can be offered again later. The processor side issues single-cycle commands. It can set the current priority, set the IPI priority, accept the pending interrupt, or signal end-of-interrupt. These commands can displace the pending interrupt, present the IPI, or ask the sources to resend. All outputs are registered, so the effect of an input sampled at one clock edge is visible right after that edge.

Top module: `intr_presenter`

## Requirements
- R1: After reset, the state word is 0, the pending priority and the IPI priority are both 0xFF, the interrupt line is low, and no reject, resend, end-of-interrupt or accept pulse is active.
- R2: A request with a non-zero source number is taken when both of the following hold. First, its priority is below the current priority (bits 31:24). Second, either nothing is pending or the pending priority is numerically greater than the request's priority. When taken, bits 23:0 get the source number, the pending priority gets the request's priority, and the line goes high. The line is high exactly while bits 23:0 are non-zero.
- R3: A request is dropped, with no change of state, in either of two cases. The first is when its priority is greater than or equal to the current priority. The second is when a pending interrupt has a priority less than or equal to the request's priority.
- R4: A request with source number 0 is ignored. A request in a cycle where a command is also valid is ignored, because commands have precedence.
- R5: When a request displaces a pending interrupt that came from the source controller, the displaced source number is sent on a reject pulse.
- R6: Accept (command code 2) returns the whole state word on the accept output and lowers the line. It then loads the word with the old pending priority in the top byte and zero below, and resets the pending priority to 0xFF. While the slot is empty, the pending priority is always 0xFF.
- R7: Writing the current priority (command code 0, data bits 7:0) to a more favoured value clears the slot when a pending interrupt's priority is not less than the new value. In that case the pending priority returns to 0xFF, the line drops, and the source is rejected if it owned the slot.
- R8: Writing the current priority to a less favoured value issues a resend pulse. It also runs the IPI check against the new value.
- R9: Setting the IPI priority (command code 1, data bits 7:0) runs the IPI check. The IPI check passes when the IPI priority is below the current priority and no pending interrupt has a priority less than or equal to it. When it passes, the slot is loaded with source number 2 and the IPI priority. Any source-owned interrupt is rejected first. A pending IPI has no owner, so displacing it produces no reject. The IPI priority is visible on its own output.
- R10: End-of-interrupt (command code 3) works as follows. Data bits 31:24 become the current priority. Data bits 23:0 go out on an end-of-interrupt pulse. A resend pulse is issued, and the IPI check runs against the new current priority.
- R11: Reject, resend, end-of-interrupt and accept are one-cycle pulses. When a reject and a resend occur in the same cycle, both pulses are driven together, and the source side applies the reject first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Presentation request from the source controller |
| req_src | input | 24 | Requested source number |
| req_prio | input | 8 | Requested priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_code | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| irq_out | output | 1 | Interrupt line to the processor |
| state_word | output | 32 | Current priority and pending source number |
| pend_prio | output | 8 | Priority of the pending interrupt |
| ipi_prio | output | 8 | IPI request priority |
| acc_valid | output | 1 | Accept result pulse |
| acc_word | output | 32 | State word captured by accept |
| rej_valid | output | 1 | Reject pulse to the source side |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse to the source side |
| eoi_src | output | 24 | Source number being completed |
| rsd_valid | output | 1 | Resend request pulse to the source side |

## Verification
On every cycle, the assertions check several rules. The line must follow the presence of a pending number. An empty slot must carry the least-favoured pending priority, and an owner must never exist without a pending number. Every reject must name the number that an owning source held one cycle earlier. A request at or below the current priority must leave the state untouched. Every end-of-interrupt must come with a resend. The assertions cannot show the priority arithmetic of each command path or the exact values latched. The bench's vector sequence covers these. It drives IPIs displacing source interrupts and the reverse, displacement by a priority write, end-of-interrupt that rejects and resends in one cycle, and requests hidden by a simultaneous command.

// File: rtl/intr_presenter.sv
module intr_presenter #(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [SRC_W-1:0]         req_src,
  input  logic [PRIO_W-1:0]        req_prio,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_code,
  input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
  output logic                     irq_out,
  output logic [PRIO_W+SRC_W-1:0]  state_word,
  output logic [PRIO_W-1:0]        pend_prio,
  output logic [PRIO_W-1:0]        ipi_prio,
  output logic                     acc_valid,
  output logic [PRIO_W+SRC_W-1:0]  acc_word,
  output logic                     rej_valid,
  output logic [SRC_W-1:0]         rej_src,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     rsd_valid
);

  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM = SRC_W'(IPI_SRC);
  localparam logic [1:0] OP_CPPR = 2'd0, OP_IPI = 2'd1, OP_ACC = 2'd2, OP_EOI = 2'd3;

  logic [WORD_W-1:0] word_q, word_n;
  logic [PRIO_W-1:0] pp_q, pp_n, mfrr_q, mfrr_n;
  logic              own_q, own_n, irq_q, irq_n;
  logic              acc_v_n, rej_v_n, eoi_v_n, rsd_v_n, do_ipi;
  logic [WORD_W-1:0] acc_w_n;
  logic [SRC_W-1:0]  rej_s_n, eoi_s_n;

  wire [PRIO_W-1:0] cppr    = word_q[WORD_W-1:SRC_W];
  wire [SRC_W-1:0]  xisr    = word_q[SRC_W-1:0];
  wire              pend    = (xisr != '0);
  wire [PRIO_W-1:0] new_pri = cmd_data[PRIO_W-1:0];

  always_comb begin
    word_n  = word_q;
    pp_n    = pp_q;
    mfrr_n  = mfrr_q;
    own_n   = own_q;
    irq_n   = irq_q;
    acc_v_n = 1'b0;
    acc_w_n = '0;
    rej_v_n = 1'b0;
    rej_s_n = '0;
    eoi_v_n = 1'b0;
    eoi_s_n = '0;
    rsd_v_n = 1'b0;
    do_ipi  = 1'b0;
    if (cmd_valid) begin
      case (cmd_code)
        OP_CPPR: begin
          word_n[WORD_W-1:SRC_W] = new_pri;
          if (new_pri < cppr) begin
            if (pend && new_pri <= pp_q) begin
              word_n[SRC_W-1:0] = '0;
              pp_n  = LEAST;
              irq_n = 1'b0;
              own_n = 1'b0;
              if (own_q) begin
                rej_v_n = 1'b1;
                rej_s_n = xisr;
              end
            end
          end else if (new_pri > cppr) begin
            rsd_v_n = 1'b1;
            do_ipi  = 1'b1;
          end
        end
        OP_IPI: begin
          mfrr_n = new_pri;
          do_ipi = 1'b1;
        end
        OP_ACC: begin
          acc_v_n = 1'b1;
          acc_w_n = word_q;
          word_n  = {pp_q, {SRC_W{1'b0}}};
          pp_n    = LEAST;
          own_n   = 1'b0;
          irq_n   = 1'b0;
        end
        default: begin
          word_n[WORD_W-1:SRC_W] = cmd_data[WORD_W-1:SRC_W];
          eoi_v_n = 1'b1;
          eoi_s_n = cmd_data[SRC_W-1:0];
          rsd_v_n = 1'b1;
          do_ipi  = 1'b1;
        end
      endcase
      if (do_ipi && (mfrr_n < word_n[WORD_W-1:SRC_W]) && !(pend && pp_q <= mfrr_n)) begin
        if (pend && own_q) begin
          rej_v_n = 1'b1;
          rej_s_n = xisr;
        end
        word_n[SRC_W-1:0] = IPI_NUM;
        pp_n  = mfrr_n;
        own_n = 1'b0;
        irq_n = 1'b1;
      end
    end else if (req_valid && req_src != '0) begin
      if (!(req_prio >= cppr || (pend && pp_q <= req_prio))) begin
        if (pend && own_q) begin
          rej_v_n = 1'b1;
          rej_s_n = xisr;
        end
        word_n[SRC_W-1:0] = req_src;
        pp_n  = req_prio;
        own_n = 1'b1;
        irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      pp_q      <= LEAST;
      mfrr_q    <= LEAST;
      own_q     <= 1'b0;
      irq_q     <= 1'b0;
      acc_valid <= 1'b0;
      acc_word  <= '0;
      rej_valid <= 1'b0;
      rej_src   <= '0;
      eoi_valid <= 1'b0;
      eoi_src   <= '0;
      rsd_valid <= 1'b0;
    end else begin
      word_q    <= word_n;
      pp_q      <= pp_n;
      mfrr_q    <= mfrr_n;
      own_q     <= own_n;
      irq_q     <= irq_n;
      acc_valid <= acc_v_n;
      acc_word  <= acc_w_n;
      rej_valid <= rej_v_n;
      rej_src   <= rej_s_n;
      eoi_valid <= eoi_v_n;
      eoi_src   <= eoi_s_n;
      rsd_valid <= rsd_v_n;
    end
  end

  assign irq_out    = irq_q;
  assign state_word = word_q;
  assign pend_prio  = pp_q;
  assign ipi_prio   = mfrr_q;

  p_line_follows_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (word_q[SRC_W-1:0] != '0));

  p_empty_least_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q[SRC_W-1:0] == '0) |-> (pp_q == LEAST));

  p_owner_has_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    own_q |-> (word_q[SRC_W-1:0] != '0));

  p_reject_names_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> ($past(own_q) && rej_src == $past(word_q[SRC_W-1:0])));

  p_drop_unfavoured_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !cmd_valid && req_prio >= word_q[WORD_W-1:SRC_W])
      |-> ($stable(word_q) && $stable(pp_q)));

  p_accept_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (word_q[SRC_W-1:0] == '0 && pp_q == LEAST && !irq_q));

  p_eoi_resends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> rsd_valid);

endmodule

// File: tb/intr_presenter_bench.sv
module intr_presenter_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cmd_valid = 0;
  logic [23:0] req_src = 0;
  logic [7:0]  req_prio = 0;
  logic [1:0]  cmd_code = 0;
  logic [31:0] cmd_data = 0;
  logic irq_out, acc_valid, rej_valid, eoi_valid, rsd_valid;
  logic [31:0] state_word, acc_word;
  logic [7:0]  pend_prio, ipi_prio;
  logic [23:0] rej_src, eoi_src;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_presenter u_intr_presenter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .irq_out(irq_out), .state_word(state_word),
    .pend_prio(pend_prio), .ipi_prio(ipi_prio), .acc_valid(acc_valid),
    .acc_word(acc_word), .rej_valid(rej_valid), .rej_src(rej_src),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src), .rsd_valid(rsd_valid));

  typedef struct packed {
    logic        cv;
    logic [1:0]  op;
    logic [31:0] d;
    logic        rv;
    logic [23:0] src;
    logic [7:0]  pr;
    logic [31:0] ew;
    logic [7:0]  ep;
    logic        ei;
    logic        erj;
    logic [23:0] ern;
    logic        ers;
    logic        eeo;
    logic        eac;
    logic [31:0] ex;
    logic [7:0]  rq;
  } vec_t;

  // ops: 0 current priority, 1 IPI priority, 2 accept, 3 end-of-interrupt
  localparam vec_t VEC [32] = '{
    '{1,0,32'h80,0,0,0,        32'h80000000,8'hFF,0,0,0,1,0,0,0,8},         // R8
    '{0,0,0,1,24'h10,8'h40,    32'h80000010,8'h40,1,0,0,0,0,0,0,2},         // R2
    '{0,0,0,1,24'h11,8'h40,    32'h80000010,8'h40,1,0,0,0,0,0,0,3},         // R3 equal pending
    '{0,0,0,1,24'h12,8'h90,    32'h80000010,8'h40,1,0,0,0,0,0,0,3},         // R3 above cppr
    '{0,0,0,1,24'h13,8'h20,    32'h80000013,8'h20,1,1,24'h10,0,0,0,0,5},    // R5
    '{1,1,32'h10,0,0,0,        32'h80000002,8'h10,1,1,24'h13,0,0,0,0,9},    // R9
    '{0,0,0,1,24'h14,8'h08,    32'h80000014,8'h08,1,0,0,0,0,0,0,9},         // R9 no owner
    '{1,2,0,0,0,0,             32'h08000000,8'hFF,0,0,0,0,0,1,32'h80000014,6}, // R6
    '{1,3,32'h80000014,0,0,0,  32'h80000002,8'h10,1,0,0,1,1,0,32'h14,10},   // R10
    '{1,0,32'h05,0,0,0,        32'h05000000,8'hFF,0,0,0,0,0,0,0,7},         // R7 ipi
    '{0,0,0,1,24'h20,8'h03,    32'h05000020,8'h03,1,0,0,0,0,0,0,2},
    '{1,0,32'h03,0,0,0,        32'h03000000,8'hFF,0,1,24'h20,0,0,0,0,7},    // R7 owned
    '{1,0,32'h40,0,0,0,        32'h40000002,8'h10,1,0,0,1,0,0,0,8},         // R8 ipi
    '{0,0,0,1,24'h21,8'h10,    32'h40000002,8'h10,1,0,0,0,0,0,0,3},
    '{0,0,0,1,24'h22,8'h0F,    32'h40000022,8'h0F,1,0,0,0,0,0,0,9},
    '{1,1,32'h0F,0,0,0,        32'h40000022,8'h0F,1,0,0,0,0,0,0,9},
    '{1,1,32'h0E,0,0,0,        32'h40000002,8'h0E,1,1,24'h22,0,0,0,0,9},
    '{1,3,32'h30000005,1,24'h23,8'h01, 32'h30000002,8'h0E,1,0,0,1,1,0,32'h5,4}, // R4
    '{0,0,0,1,24'h0,8'h00,     32'h30000002,8'h0E,1,0,0,0,0,0,0,4},
    '{0,0,0,1,24'h24,8'h02,    32'h30000024,8'h02,1,0,0,0,0,0,0,2},
    '{1,1,32'h01,0,0,0,        32'h30000002,8'h01,1,1,24'h24,0,0,0,0,9},
    '{1,2,0,0,0,0,             32'h01000000,8'hFF,0,0,0,0,0,1,32'h30000002,6},
    '{1,3,32'h60000002,0,0,0,  32'h60000002,8'h01,1,0,0,1,1,0,32'h2,10},
    '{1,1,32'h50,0,0,0,        32'h60000002,8'h01,1,0,0,0,0,0,0,9},
    '{1,2,0,0,0,0,             32'h01000000,8'hFF,0,0,0,0,0,1,32'h60000002,6},
    '{1,3,32'h70000000,0,0,0,  32'h70000002,8'h50,1,0,0,1,1,0,32'h0,10},
    '{0,0,0,1,24'h26,8'h30,    32'h70000026,8'h30,1,0,0,0,0,0,0,2},
    '{1,1,32'h20,0,0,0,        32'h70000002,8'h20,1,1,24'h26,0,0,0,0,9},
    '{0,0,0,1,24'h27,8'h10,    32'h70000027,8'h10,1,0,0,0,0,0,0,2},
    '{1,3,32'h05000000,0,0,0,  32'h05000027,8'h10,1,0,0,1,1,0,32'h0,10},
    '{1,1,32'h08,0,0,0,        32'h05000027,8'h10,1,0,0,0,0,0,0,9},
    '{1,3,32'h80000000,0,0,0,  32'h80000002,8'h08,1,1,24'h27,1,1,0,32'h0,11} // R11
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "irq_out", 32'(irq_out), 0);
    chk(tag, "state_word", state_word, 0);
    chk(tag, "pend_prio", 32'(pend_prio), 32'hFF);
    chk(tag, "ipi_prio", 32'(ipi_prio), 32'hFF);
    chk(tag, "pulses", {28'd0, rej_valid, rsd_valid, eoi_valid, acc_valid}, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    #1;
    chk_idle("R1");
    rst_n = 1;
    @(posedge clk); #1;
    chk_idle("R1");
    for (int i = 0; i < 32; i++) begin
      cmd_valid = VEC[i].cv; cmd_code = VEC[i].op; cmd_data = VEC[i].d;
      req_valid = VEC[i].rv; req_src = VEC[i].src; req_prio = VEC[i].pr;
      @(posedge clk); #1;
      cmd_valid = 0; req_valid = 0;
      tag = $sformatf("R%0d v%0d", VEC[i].rq, i);
      chk(tag, "state_word", state_word, VEC[i].ew);
      chk(tag, "pend_prio", 32'(pend_prio), 32'(VEC[i].ep));
      chk(tag, "irq_out", 32'(irq_out), 32'(VEC[i].ei));
      chk(tag, "rej_valid", 32'(rej_valid), 32'(VEC[i].erj));
      if (VEC[i].erj) chk(tag, "rej_src", 32'(rej_src), 32'(VEC[i].ern));
      chk(tag, "rsd_valid", 32'(rsd_valid), 32'(VEC[i].ers));
      chk(tag, "eoi_valid", 32'(eoi_valid), 32'(VEC[i].eeo));
      if (VEC[i].eeo) chk(tag, "eoi_src", 32'(eoi_src), VEC[i].ex);
      chk(tag, "acc_valid", 32'(acc_valid), 32'(VEC[i].eac));
      if (VEC[i].eac) chk(tag, "acc_word", acc_word, VEC[i].ex);
    end
    // R11: pulses last one cycle
    @(posedge clk); #1;
    chk("R11", "pulses after idle", {28'd0, rej_valid, rsd_valid, eoi_valid, acc_valid}, 0);
    chk("R11", "state held", state_word, 32'h80000002);
    chk("R9", "ipi_prio", 32'(ipi_prio), 32'h08);
    // R1: reset in mid-run
    rst_n = 0;
    #2;
    chk_idle("R1");
    rst_n = 1;
    @(posedge clk); #1;
    chk_idle("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule